// File: doc/BRIEF.md
# Steered and Throttled Interrupt Controller

This block gathers per-path interrupt events from 12 transmit paths, 12 receive paths and 12 nearly-empty sources (36 events). Each event is latched in a status bit, gated by an enable bit and routed to one of 16 vectors through a 4-bit selector field. Each vector is paced by its own throttle timer, which counts in ticks of a fixed time base. A tick is `TICK_DIV` core clocks; at 100 MHz with `TICK_DIV` = 25 this is 250 ns, close to the 256 ns unit. The result is one request pulse per vector. Another block turns these pulses into messages on the bus.

Software reaches the block through a flat 32-bit register port. The port has a word address, a write strobe, a read strobe and combinational read data. Status is cleared by reading it. It can also be cleared or set through write-one aliases. The enables can be written directly or changed through set and clear aliases. An optional auto-clear mode removes status bits as soon as their vector fires, so software does not have to read them.

Top module: `irq_steer_throttle`

## Requirements
- R1: Event index i is status bit i: transmit path p is i=p, receive path p is i=12+p, nearly-empty source p is i=24+p. Status word 0 (address 0) holds bits 0..31. Status word 1 (address 1) holds indices 32..35 in its bits 0..3.
- R2: A read strobe on address 0 or 1 returns the status word and clears every bit it returned.
- R3: Writing addresses 2/3 clears, and writing addresses 4/5, sets the status bits of word 0/1 where the data bit is one. All other bits are left unchanged.
- R4: The enable words at addresses 6/7 are read-write, and an enable bit of 1 lets its event fire. Writing addresses 8/9 sets, and writing addresses 10/11 clears, only the enable bits written as one.
- R5: The vector selector for event i is bits 4*(i%8)+3..4*(i%8) of the word at address 12+i/8 (addresses 12..16, read-write). All selectors reset to vector 0.
- R6: A vector raises a one-cycle pulse on `irq` in the cycle after an enabled, pending event mapped to it becomes visible in status. A latched event whose enable bit is 0 raises no pulse.
- R7: Once a vector has fired, it does not fire again until none of its enabled events is pending.
- R8: The throttle word of vector v is at address 32+v. Bits 15..0 hold the interval (read-write) and bits 31..16 hold the counter (read-only). Firing loads the counter with the interval, and the counter then drops by one per tick of `TICK_DIV` clocks. A vector fires only when its counter is zero, so an interval of 0 means no throttling.
- R9: When bit 0 of the control word at address 20 is 1, the enabled status bits mapped to a firing vector are cleared in the same cycle the vector fires.
- R10: An event input that is high in the same cycle as any clear of its status bit leaves the bit set.
- R11: After reset, all status, enable, selector, interval, counter and control bits are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_tx | input | 12 | Transmit path events, one per path |
| evt_rx | input | 12 | Receive path events, one per path |
| evt_ne | input | 12 | Nearly-empty events, one per path |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives clear-on-read) |
| addr | input | 6 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 16 | Per-vector request pulses |

## Verification
A stale status or enable bit shows up at the next read of its word, and as a pulse on the wrong vector, or a missing pulse, one cycle after the event. A counter that is not reloaded or does not count down makes the gap between two pulses of a throttled vector fall outside the window of interval ticks. That shows within one interval. A stuck per-vector fired flag shows as a repeated pulse, or as a second event that is never answered. The bench measures pulse counts and gaps per vector and checks the status words after each scenario.

// File: rtl/irq_steer_throttle.sv
module irq_steer_throttle #(
  parameter int NPATH    = 12,
  parameter int NVEC     = 16,
  parameter int TICK_DIV = 25,
  parameter int IVW      = 16,
  parameter int AW       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPATH-1:0] evt_tx,
  input  logic [NPATH-1:0] evt_rx,
  input  logic [NPATH-1:0] evt_ne,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic [NVEC-1:0]  irq
);
  localparam int NEVT  = 3 * NPATH;
  localparam int VW    = $clog2(NVEC);
  localparam int NSELW = (NEVT * VW + 31) / 32;
  localparam int PW    = $clog2(TICK_DIV);
  localparam logic [AW-1:0] A_STAT0 = AW'(0),  A_STAT1 = AW'(1);
  localparam logic [AW-1:0] A_SCLR0 = AW'(2),  A_SCLR1 = AW'(3);
  localparam logic [AW-1:0] A_SSET0 = AW'(4),  A_SSET1 = AW'(5);
  localparam logic [AW-1:0] A_EN0   = AW'(6),  A_EN1   = AW'(7);
  localparam logic [AW-1:0] A_ESET0 = AW'(8),  A_ESET1 = AW'(9);
  localparam logic [AW-1:0] A_ECLR0 = AW'(10), A_ECLR1 = AW'(11);
  localparam int A_SEL = 12;
  localparam logic [AW-1:0] A_CTRL = AW'(20);
  localparam int A_THR = 32;

  logic [NEVT-1:0]           stat, en, stat_n, en_n, acl;
  logic [NSELW*32-1:0]       sel;
  logic                      autoclr;
  logic [NVEC-1:0][IVW-1:0]  ival, cnt;
  logic [NVEC-1:0]           hit, fire, held, irq_q;
  logic [PW-1:0]             pre;
  logic                      tick;
  logic [NEVT-1:0]           evt_all;
  logic [63:0]               stat64, en64;

  assign evt_all = {evt_ne, evt_rx, evt_tx};
  assign stat64  = 64'(stat);
  assign en64    = 64'(en);
  assign tick    = (pre == PW'(TICK_DIV - 1));
  assign irq     = irq_q;

  function automatic logic [63:0] wpair(input logic [AW-1:0] a0, input logic [AW-1:0] a1);
    wpair = {(wr_en && addr == a1) ? wdata : 32'd0, (wr_en && addr == a0) ? wdata : 32'd0};
  endfunction

  always_comb begin
    hit = '0;
    for (int v = 0; v < NVEC; v++)
      for (int i = 0; i < NEVT; i++)
        if (stat[i] && en[i] && sel[i*VW +: VW] == VW'(v)) hit[v] = 1'b1;
    for (int v = 0; v < NVEC; v++)
      fire[v] = hit[v] && cnt[v] == '0 && !held[v];
    for (int i = 0; i < NEVT; i++)
      acl[i] = autoclr && stat[i] && en[i] && fire[sel[i*VW +: VW]];
  end

  always_comb begin
    logic [63:0] rdclr, e;
    rdclr = {(rd_en && addr == A_STAT1) ? stat64[63:32] : 32'd0,
             (rd_en && addr == A_STAT0) ? stat64[31:0]  : 32'd0};
    stat_n = (stat & ~(rdclr[NEVT-1:0] | wpair(A_SCLR0, A_SCLR1)[NEVT-1:0] | acl))
           | wpair(A_SSET0, A_SSET1)[NEVT-1:0] | evt_all;
    e = en64;
    if (wr_en && addr == A_EN0) e[31:0]  = wdata;
    if (wr_en && addr == A_EN1) e[63:32] = wdata;
    e = (e | wpair(A_ESET0, A_ESET1)) & ~wpair(A_ECLR0, A_ECLR1);
    en_n = e[NEVT-1:0];
  end

  always_comb begin
    rdata = 32'd0;
    case (addr)
      A_STAT0: rdata = stat64[31:0];
      A_STAT1: rdata = stat64[63:32];
      A_EN0:   rdata = en64[31:0];
      A_EN1:   rdata = en64[63:32];
      A_CTRL:  rdata = {31'd0, autoclr};
      default: rdata = 32'd0;
    endcase
    for (int w = 0; w < NSELW; w++)
      if (addr == AW'(A_SEL + w)) rdata = sel[w*32 +: 32];
    for (int v = 0; v < NVEC; v++)
      if (addr == AW'(A_THR + v)) rdata = (32'(cnt[v]) << 16) | 32'(ival[v]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0; en <= '0; sel <= '0; autoclr <= 1'b0; pre <= '0;
      ival <= '0; cnt <= '0; held <= '0; irq_q <= '0;
    end else begin
      stat  <= stat_n;
      en    <= en_n;
      pre   <= tick ? '0 : pre + 1'b1;
      irq_q <= fire;
      if (wr_en && addr == A_CTRL) autoclr <= wdata[0];
      for (int w = 0; w < NSELW; w++)
        if (wr_en && addr == AW'(A_SEL + w)) sel[w*32 +: 32] <= wdata;
      for (int v = 0; v < NVEC; v++) begin
        if (wr_en && addr == AW'(A_THR + v)) ival[v] <= wdata[IVW-1:0];
        if (fire[v])                         cnt[v] <= ival[v];
        else if (tick && cnt[v] != '0)       cnt[v] <= cnt[v] - 1'b1;
        held[v] <= hit[v] && (held[v] || fire[v]);
      end
    end
  end
endmodule

module irq_steer_throttle_chk #(
  parameter int NEVT = 36,
  parameter int NVEC = 16,
  parameter int IVW  = 16,
  parameter int AW   = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NEVT-1:0]          evt_all,
  input logic [NEVT-1:0]          stat,
  input logic [NEVT-1:0]          en,
  input logic [NVEC-1:0]          irq,
  input logic [NVEC-1:0][IVW-1:0] cnt,
  input logic [NVEC-1:0][IVW-1:0] ival,
  input logic                     rd_en,
  input logic                     wr_en,
  input logic [AW-1:0]            addr
);
  logic [63:0] s64, e64;
  assign s64 = 64'(stat);
  assign e64 = 64'(evt_all);

  a_r6_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> (irq == '0));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |=> ((irq & $past(irq)) == '0));
  a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == AW'(0) && e64[31:0] == 32'd0) |=> (s64[31:0] == 32'd0));
  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_all != '0) |=> ((stat & $past(evt_all)) == $past(evt_all)));

  for (genvar v = 0; v < NVEC; v++) begin : g_v
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
      irq[v] |-> (cnt[v] == ival[v]));
    a_r8_expired: assert property (@(posedge clk) disable iff (!rst_n)
      irq[v] |-> ($past(cnt[v]) == '0));
  end
endmodule

bind irq_steer_throttle irq_steer_throttle_chk #(
  .NEVT(3 * NPATH), .NVEC(NVEC), .IVW(IVW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_all(evt_all), .stat(stat), .en(en),
  .irq(irq), .cnt(cnt), .ival(ival), .rd_en(rd_en), .wr_en(wr_en), .addr(addr)
);

// File: tb/tb_irq_steer_throttle.sv
module tb_irq_steer_throttle;
  localparam int DIV = 4;
  logic clk = 0, rst_n = 0;
  logic [11:0] evt_tx = 0, evt_rx = 0, evt_ne = 0;
  logic wr_en = 0, rd_en = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [15:0] irq;
  int checks = 0, errors = 0, cyc = 0;
  int icnt[16], last[16], prevf[16];

  irq_steer_throttle #(.TICK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .evt_tx(evt_tx), .evt_rx(evt_rx), .evt_ne(evt_ne),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk)
    if (rst_n)
      for (int v = 0; v < 16; v++)
        if (irq[v]) begin icnt[v]++; prevf[v] = last[v]; last[v] = cyc; end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = 6'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = 6'(a);
    #4 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse(input int i);
    @(negedge clk);
    if (i < 12) evt_tx[i] = 1; else if (i < 24) evt_rx[i-12] = 1; else evt_ne[i-24] = 1;
    @(negedge clk); evt_tx = 0; evt_rx = 0; evt_ne = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clean();
    logic [31:0] d;
    wr(6, 0); wr(7, 0); wr(20, 0); idle(2); rd(0, d); rd(1, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d);  check(d == 0, "R11 status0", d, 0);
    rd(6, d);  check(d == 0, "R11 enable0", d, 0);
    rd(12, d); check(d == 0, "R11 selector", d, 0);
    rd(34, d); check(d == 0, "R11 throttle", d, 0);
    check(irq == 0, "R11 irq", irq, 0);
  endtask

  task automatic t_layout_masked();
    logic [31:0] d; int c0;
    clean(); c0 = icnt[0];
    pulse(1); pulse(15); pulse(35); idle(4);
    check(icnt[0] == c0, "R6 disabled event no pulse", icnt[0] - c0, 0);
    rd(0, d); check(d == 32'h0000_8002, "R1 status0 layout", d, 32'h8002);
    rd(1, d); check(d == 32'h8, "R1 status1 nearly-empty", d, 8);
    rd(0, d); check(d == 0, "R2 clear on read", d, 0);
    rd(1, d); check(d == 0, "R2 clear on read word1", d, 0);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    clean();
    wr(4, 32'h0000_00F0); wr(5, 32'h5);
    wr(2, 32'h0000_0030);
    rd(0, d); check(d == 32'hC0, "R3 set then clear", d, 32'hC0);
    rd(1, d); check(d == 32'h5, "R3 set word1", d, 5);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    clean();
    wr(6, 32'h0F0); wr(8, 32'h3); wr(10, 32'h30); wr(9, 32'h9);
    rd(6, d); check(d == 32'hC3, "R4 enable aliases", d, 32'hC3);
    rd(7, d); check(d == 32'h9, "R4 enable word1 set", d, 9);
  endtask

  task automatic t_steer();
    logic [31:0] d; int c9, c0;
    clean(); wr(20, 1);
    wr(13, 32'h9000_0000);
    rd(13, d); check(d == 32'h9000_0000, "R5 selector readback", d, 32'h90000000);
    wr(8, 32'h0000_8000);
    c9 = icnt[9]; c0 = icnt[0];
    pulse(15); idle(4);
    check(icnt[9] == c9 + 1, "R6 pulse on steered vector", icnt[9] - c9, 1);
    check(icnt[0] == c0, "R5 default vector untouched", icnt[0] - c0, 0);
    rd(0, d); check(d == 0, "R9 autoclear removed status", d, 0);
  endtask

  task automatic t_hold();
    logic [31:0] d; int c0;
    clean(); wr(12, 0); wr(8, 32'h1);
    c0 = icnt[0];
    pulse(0); idle(10);
    check(icnt[0] == c0 + 1, "R7 one pulse while pending", icnt[0] - c0, 1);
    rd(0, d); check(d == 1, "R9 no autoclear keeps status", d, 1);
    pulse(0); idle(4);
    check(icnt[0] == c0 + 2, "R7 refire after drain", icnt[0] - c0, 2);
  endtask

  task automatic t_throttle();
    logic [31:0] d; int c2, gap;
    clean(); wr(34, 3); wr(12, 32'h0020_0000); wr(20, 1); wr(8, 32'h20);
    rd(34, d); check(d[15:0] == 3, "R8 interval readback", d[15:0], 3);
    c2 = icnt[2];
    pulse(5); idle(1); pulse(5); idle(25);
    gap = last[2] - prevf[2];
    check(icnt[2] == c2 + 2, "R8 throttled pulses", icnt[2] - c2, 2);
    check(gap >= 2 * DIV + 1 && gap <= 3 * DIV + 2, "R8 throttle gap", gap, 3 * DIV);
    wr(34, 0); c2 = icnt[2];
    pulse(5); idle(1); pulse(5); idle(4);
    gap = last[2] - prevf[2];
    check(icnt[2] == c2 + 2 && gap <= 4, "R8 interval zero unthrottled", gap, 3);
  endtask

  task automatic t_race();
    logic [31:0] d;
    clean();
    @(negedge clk); evt_tx[4] = 1; wr_en = 1; addr = 6'd2; wdata = 32'h10;
    @(negedge clk); evt_tx = 0; wr_en = 0;
    rd(0, d); check(d == 32'h10, "R10 event beats clear", d, 32'h10);
    @(negedge clk); evt_tx[4] = 1; rd_en = 1; addr = 6'd0;
    @(negedge clk); evt_tx = 0; rd_en = 0;
    rd(0, d); check(d == 32'h10, "R10 event beats read clear", d, 32'h10);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int v = 0; v < 16; v++) begin icnt[v] = 0; last[v] = 0; prevf[v] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_layout_masked();
    t_set_clear();
    t_enable();
    t_steer();
    t_hold();
    t_throttle();
    t_race();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule